// File: doc/BRIEF.md
# Cache-Line Burst Read Controller

This block is the master side of a cache-line read on a 64-bit data bus. The core asks for a line with a request pulse, a line address, a cacheability hint and a page write-through hint. The controller raises an address strobe for one clock and drives the address and both hints with it. From the next clock on it accepts quadwords, one for each clock in which system logic returns ready. Any number of wait states may come between quadwords.

At the first ready the controller combines its own hints with two responses from system logic: cache-enable and writeback-select. These responses decide two things. The first is whether the cycle is a four-quadword burst or a single transfer. The second is the coherency state given to the line. If system logic raises the next-address input while the first quadword is still waiting for ready, the two responses are captured at that moment instead of at the first ready.

A burst delivers its quadwords in an interleaved order: the index of each quadword inside the line is the starting index XORed with the beat number. The last accepted quadword carries a done pulse and the final line-state code. A request is ignored while a cycle is in progress.

Top module: `line_fill_ctrl`

## Requirements
- R1: While `rst_ni` is low, `busy_o`, `addr_strobe_o`, `qw_valid_o` and `done_o` are all 0, and an active cycle is abandoned at once.
- R2: A request accepted in idle gives exactly one clock of `addr_strobe_o` in the next cycle. That clock carries `bus_addr_o` (the request address with bits 2:0 cleared), `bus_cacheable_o` equal to the cacheability hint and `bus_wt_o` equal to the write-through hint. Both bus hints are 0 outside the strobe.
- R3: No quadword is accepted in the strobe clock. From the next clock on, `qw_valid_o` equals `rdy_i`, in the same cycle, and `qw_data_o` passes `bus_data_i` through.
- R4: The cycle is a four-quadword burst only when the cacheability hint was 1 and the effective cache-enable is 1. Otherwise it ends with the first quadword.
- R5: Beat k (0 to 3) reports `qw_addr_o` with bits 4:3 equal to the starting bits 4:3 XOR k, bits 2:0 equal to 0, and the upper bits taken from the request.
- R6: `done_o` is 1 together with the last quadword only: the first quadword of a single transfer, or the fourth quadword of a burst.
- R7: `line_state_o` at done uses the codes 2'b00 for invalid, 2'b01 for write-through shared and 2'b10 for exclusive writeback. A single transfer gives 00. A burst gives 10 when the write-through hint is 0 and the effective writeback-select is 1; any other burst gives 01.
- R8: If `next_addr_i` is 1 in a clock of the first data phase before its ready, cache-enable and writeback-select are captured in that clock. Their values at the first ready and at all later beats are then ignored. Without next-address, they are taken at the first ready only.
- R9: A request raised while `busy_o` is 1 is ignored: no strobe follows it, and `busy_o` is 0 in the clock after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Line read request from the core |
| req_addr_i | input | ADDR_W | Byte address of the requested quadword |
| req_cacheable_i | input | 1 | Core hint: line may be cached |
| req_wt_i | input | 1 | Core hint: page is write-through |
| busy_o | output | 1 | A cycle is in progress |
| addr_strobe_o | output | 1 | Address strobe, one clock |
| bus_addr_o | output | ADDR_W | Quadword-aligned bus address |
| bus_cacheable_o | output | 1 | Cacheable indication, valid with the strobe |
| bus_wt_o | output | 1 | Write-through indication, valid with the strobe |
| rdy_i | input | 1 | System ready for the current quadword |
| next_addr_i | input | 1 | System early-sample request |
| cache_en_i | input | 1 | System cache-enable response |
| wb_sel_i | input | 1 | System writeback (1) / writethrough (0) response |
| bus_data_i | input | DATA_W | Read data bus |
| qw_valid_o | output | 1 | Quadword accepted this clock |
| qw_addr_o | output | ADDR_W | Address of the accepted quadword |
| qw_data_o | output | DATA_W | Accepted quadword |
| done_o | output | 1 | Last quadword of the cycle |
| line_state_o | output | 2 | Final line state, valid with done |

## Verification
The bound checker watches rules that must hold in every clock. The strobe lasts a single clock and never coincides with an accepted quadword. Done always comes with a valid quadword and is followed by idle. A request seen while busy never brings a strobe in the next clock. Only the bench scenarios can show the outcomes that depend on the data. These include the burst length and the line-state code for every combination of the hints, the interleaved address order from each starting index, and early sampling overriding conflicting values at ready. They also include responses that change during wait states and later beats and have no effect, and a reset in the middle of a cycle.

// File: rtl/line_fill_pkg.sv
package line_fill_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_EXC = 2'b10
  } line_state_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ADDR = 2'b01,
    ST_DATA = 2'b10
  } bus_state_e;
endpackage

// File: rtl/line_fill_seq.sv
module line_fill_seq
  import line_fill_pkg::*;
#(
  parameter int unsigned BEATS = 4,
  localparam int unsigned IDX_W = $clog2(BEATS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             rdy_i,
  input  logic             burst_i,
  output bus_state_e       state_o,
  output logic [IDX_W-1:0] beat_o,
  output logic             accept_o,
  output logic             first_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] BeatMax = IDX_W'(BEATS - 1);

  bus_state_e       st_q;
  logic [IDX_W-1:0] beat_q;

  assign accept_o = (st_q == ST_IDLE) && req_i;
  assign first_o  = (beat_q == '0);
  assign last_o   = (st_q == ST_DATA) && rdy_i &&
                    (first_o ? !burst_i : (beat_q == BeatMax));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          beat_q <= '0;
          if (req_i) st_q <= ST_ADDR;
        end
        ST_ADDR: st_q <= ST_DATA;
        ST_DATA: begin
          if (rdy_i) begin
            if (last_o) begin
              st_q   <= ST_IDLE;
              beat_q <= '0;
            end else begin
              beat_q <= beat_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = st_q;
  assign beat_o  = beat_q;
endmodule

// File: rtl/line_fill_addr.sv
module line_fill_addr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BEATS  = 4,
  localparam int unsigned IDX_W = $clog2(BEATS),
  localparam int unsigned LO    = 3,
  localparam int unsigned HI_W  = ADDR_W - LO - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_cacheable_i,
  input  logic              req_wt_i,
  input  logic [IDX_W-1:0]  beat_i,
  output logic [ADDR_W-1:0] base_addr_o,
  output logic [ADDR_W-1:0] qw_addr_o,
  output logic              cacheable_o,
  output logic              wt_o
);
  logic [HI_W-1:0]  hi_q;
  logic [IDX_W-1:0] idx_q;
  logic             cach_q, wt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      idx_q  <= '0;
      cach_q <= 1'b0;
      wt_q   <= 1'b0;
    end else if (accept_i) begin
      hi_q   <= req_addr_i[ADDR_W-1:LO+IDX_W];
      idx_q  <= req_addr_i[LO+IDX_W-1:LO];
      cach_q <= req_cacheable_i;
      wt_q   <= req_wt_i;
    end
  end

  // Interleaved order: beat index XOR starting index
  assign base_addr_o = {hi_q, idx_q, {LO{1'b0}}};
  assign qw_addr_o   = {hi_q, idx_q ^ beat_i, {LO{1'b0}}};
  assign cacheable_o = cach_q;
  assign wt_o        = wt_q;
endmodule

// File: rtl/line_fill_decide.sv
module line_fill_decide
  import line_fill_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  bus_state_e  state_i,
  input  logic        first_i,
  input  logic        rdy_i,
  input  logic        next_addr_i,
  input  logic        cache_en_i,
  input  logic        wb_sel_i,
  input  logic        cacheable_i,
  input  logic        wt_i,
  output logic        burst_o,
  output line_state_e line_state_o
);
  logic        early_q, ken_q, wb_q;
  logic        ken_eff, wb_eff;
  line_state_e ls_now, ls_q;
  logic        in_first;

  assign in_first = (state_i == ST_DATA) && first_i;
  assign ken_eff  = early_q ? ken_q : cache_en_i;
  assign wb_eff   = early_q ? wb_q  : wb_sel_i;
  assign burst_o  = cacheable_i && ken_eff;

  always_comb begin
    if (!burst_o)               ls_now = LS_INV;
    else if (!wt_i && wb_eff)   ls_now = LS_EXC;
    else                        ls_now = LS_SHR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      early_q <= 1'b0;
      ken_q   <= 1'b0;
      wb_q    <= 1'b0;
      ls_q    <= LS_INV;
    end else begin
      if (state_i != ST_DATA) begin
        early_q <= 1'b0;
      end else if (in_first && !rdy_i && next_addr_i && !early_q) begin
        early_q <= 1'b1;
        ken_q   <= cache_en_i;
        wb_q    <= wb_sel_i;
      end
      if (in_first && rdy_i) ls_q <= ls_now;
    end
  end

  assign line_state_o = in_first ? ls_now : ls_q;
endmodule

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl
  import line_fill_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned BEATS  = 4,
  localparam int unsigned IDX_W = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_cacheable_i,
  input  logic              req_wt_i,
  output logic              busy_o,
  output logic              addr_strobe_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_cacheable_o,
  output logic              bus_wt_o,
  input  logic              rdy_i,
  input  logic              next_addr_i,
  input  logic              cache_en_i,
  input  logic              wb_sel_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              qw_valid_o,
  output logic [ADDR_W-1:0] qw_addr_o,
  output logic [DATA_W-1:0] qw_data_o,
  output logic              done_o,
  output logic [1:0]        line_state_o
);
  bus_state_e       state;
  logic [IDX_W-1:0] beat;
  logic             accept, first, last, burst;
  logic             cach, wt;
  line_state_e      ls;

  line_fill_seq #(.BEATS(BEATS)) u_seq (
    .clk_i, .rst_ni, .req_i, .rdy_i,
    .burst_i  (burst),
    .state_o  (state),
    .beat_o   (beat),
    .accept_o (accept),
    .first_o  (first),
    .last_o   (last)
  );

  line_fill_addr #(.ADDR_W(ADDR_W), .BEATS(BEATS)) u_addr (
    .clk_i, .rst_ni,
    .accept_i        (accept),
    .req_addr_i,
    .req_cacheable_i,
    .req_wt_i,
    .beat_i          (beat),
    .base_addr_o     (bus_addr_o),
    .qw_addr_o,
    .cacheable_o     (cach),
    .wt_o            (wt)
  );

  line_fill_decide u_dec (
    .clk_i, .rst_ni,
    .state_i      (state),
    .first_i      (first),
    .rdy_i,
    .next_addr_i,
    .cache_en_i,
    .wb_sel_i,
    .cacheable_i  (cach),
    .wt_i         (wt),
    .burst_o      (burst),
    .line_state_o (ls)
  );

  assign busy_o          = (state != ST_IDLE);
  assign addr_strobe_o   = (state == ST_ADDR);
  assign bus_cacheable_o = addr_strobe_o && cach;
  assign bus_wt_o        = addr_strobe_o && wt;
  assign qw_valid_o      = (state == ST_DATA) && rdy_i;
  assign qw_data_o       = bus_data_i;
  assign done_o          = last;
  assign line_state_o    = ls;
endmodule

// File: rtl/line_fill_ctrl_chk.sv
module line_fill_ctrl_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              busy_o,
  input logic              addr_strobe_o,
  input logic              bus_cacheable_o,
  input logic              bus_wt_o,
  input logic              qw_valid_o,
  input logic              done_o,
  input logic [1:0]        line_state_o
);
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_strobe_o |=> !addr_strobe_o);                                     // R2
  AST_HINTS_WITH_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cacheable_o || bus_wt_o) |-> addr_strobe_o);                      // R2
  AST_NO_DATA_AT_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_strobe_o |-> !qw_valid_o);                                        // R3
  AST_DONE_WITH_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (qw_valid_o && line_state_o != 2'b11));                     // R6
  AST_DONE_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);                                                   // R9
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_i) |=> !addr_strobe_o);                                 // R9
endmodule

bind line_fill_ctrl line_fill_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .req_i, .busy_o, .addr_strobe_o, .bus_cacheable_o,
  .bus_wt_o, .qw_valid_o, .done_o, .line_state_o
);

// File: tb/tb_line_fill_ctrl.sv
module tb_line_fill_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        req_cacheable_i = 1'b0, req_wt_i = 1'b0;
  logic        busy_o, addr_strobe_o, bus_cacheable_o, bus_wt_o;
  logic [31:0] bus_addr_o, qw_addr_o;
  logic        rdy_i = 1'b0, next_addr_i = 1'b0, cache_en_i = 1'b0, wb_sel_i = 1'b0;
  logic [63:0] bus_data_i = '0, qw_data_o;
  logic        qw_valid_o, done_o;
  logic [1:0]  line_state_o;

  int checks = 0, fails = 0, cyc = 0;

  line_fill_ctrl dut (.*);

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected < 150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_state(bit c, bit wt, bit ken, bit wb);
    if (!(c && ken)) return 2'b00;
    if (!wt && wb)   return 2'b10;
    return 2'b01;
  endfunction

  // One full line read; ek/ew are the effective responses, early selects next-address capture
  task automatic run_line(input logic [31:0] a, input bit c, input bit wt,
                          input bit ek, input bit ew, input bit early,
                          input bit bad_req, input int maxw);
    int beats;
    logic [31:0] base;
    logic [63:0] d;
    base  = {a[31:3], 3'b000};
    beats = (c && ek) ? 4 : 1;
    @(negedge clk_i);
    req_i = 1'b1; req_addr_i = a; req_cacheable_i = c; req_wt_i = wt;
    @(negedge clk_i);
    req_i = 1'b0;
    #1;
    chk("R2 strobe", addr_strobe_o, 1);
    chk("R2 addr", bus_addr_o, base);
    chk("R2 cacheable", bus_cacheable_o, c);
    chk("R2 wt", bus_wt_o, wt);
    chk("R3 no data at strobe", qw_valid_o, 0);
    @(negedge clk_i);
    for (int b = 0; b < beats; b++) begin
      int nw;
      nw = $urandom_range(maxw, 0);
      if (early && b == 0 && nw == 0) nw = 1;
      for (int w = 0; w < nw; w++) begin
        rdy_i = 1'b0;
        next_addr_i = early && b == 0 && w == nw - 1;
        if (next_addr_i) begin
          cache_en_i = ek; wb_sel_i = ew;
        end else begin
          cache_en_i = $urandom_range(1, 0); wb_sel_i = $urandom_range(1, 0);
        end
        req_i = bad_req && w == 0;
        #1;
        chk("R3 wait no valid", qw_valid_o, 0);
        chk("R2 strobe off", addr_strobe_o, 0);
        @(negedge clk_i);
      end
      req_i = 1'b0; next_addr_i = 1'b0; rdy_i = 1'b1;
      d = {$urandom, $urandom};
      bus_data_i = d;
      if (b == 0) begin
        cache_en_i = early ? ~ek : ek;   // R8 conflicting values ignored after capture
        wb_sel_i   = early ? ~ew : ew;
      end else begin
        cache_en_i = $urandom_range(1, 0); wb_sel_i = $urandom_range(1, 0);
      end
      #1;
      chk("R3 valid", qw_valid_o, 1);
      chk("R3 data", qw_data_o, d);
      chk("R5 beat addr", qw_addr_o, base ^ (32'(b) << 3));
      chk("R4 R6 done", done_o, b == beats - 1);
      if (b == beats - 1)
        chk("R7 R8 line state", line_state_o, exp_state(c, wt, ek, ew));
      @(negedge clk_i);
    end
    rdy_i = 1'b0;
    #1;
    chk("R9 idle after done", busy_o, 0);
    chk("R9 no strobe", addr_strobe_o, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    #1;
    chk("R1 busy in reset", busy_o, 0);
    chk("R1 strobe in reset", addr_strobe_o, 0);
    chk("R1 done in reset", done_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // Directed: each start index, every hint combination
    for (int s = 0; s < 4; s++)
      run_line(32'h1234_5600 | (s << 3) | 3'h5, 1, 0, 1, 1, 0, 0, 0);  // R5 R7 exclusive
    run_line(32'hA000_0010, 1, 1, 1, 1, 0, 0, 2);   // R7 shared via wt hint
    run_line(32'hA000_0018, 1, 0, 1, 0, 0, 0, 2);   // R7 shared via wb_sel
    run_line(32'hA000_0008, 0, 0, 1, 1, 0, 0, 1);   // R4 uncached hint
    run_line(32'hA000_0008, 1, 0, 0, 1, 0, 0, 1);   // R4 cache_en low
    run_line(32'hB000_0000, 1, 0, 1, 1, 1, 0, 2);   // R8 early burst
    run_line(32'hB000_0008, 1, 0, 0, 1, 1, 0, 2);   // R8 early single
    run_line(32'hC000_0010, 1, 0, 1, 1, 0, 1, 2);   // R9 request while busy

    // Random
    for (int i = 0; i < 300; i++)
      run_line($urandom, $urandom_range(1, 0), $urandom_range(1, 0),
               $urandom_range(1, 0), $urandom_range(1, 0), $urandom_range(1, 0),
               $urandom_range(1, 0), 3);

    // R1 reset mid-cycle
    @(negedge clk_i);
    req_i = 1'b1; req_addr_i = 32'hD000_0000; req_cacheable_i = 1'b1; req_wt_i = 1'b0;
    @(negedge clk_i); req_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 busy cleared", busy_o, 0);
    chk("R1 valid cleared", qw_valid_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    run_line(32'hD000_0018, 1, 0, 1, 1, 0, 0, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule